// File: doc/BRIEF.md
# Miss Tracking Request Unit

This unit sits on the processor side of a shared-memory network interface. Load and store requests arrive on a valid/ready stream. Each request carries a write flag, a cacheable flag, an address, write data and a reply tag. The tag tells the processor where the answer belongs, for example which register receives the load data. Every accepted request is held in one of a small set of miss tracking entries until its reply has been handed back.

Each entry moves through four states: idle, pending, requested and complete. A newly accepted request is pending. When its message has been accepted by the network it becomes requested. When a reply naming its entry index arrives it becomes complete. When the reply register stream takes it, the entry returns to idle.

All three data streams use valid/ready and follow the same back-pressure rules. A producer that raises valid keeps it high, and keeps its payload unchanged, until the cycle in which ready is high. A transfer happens in any cycle where both valid and ready are high. The reply receive port is always ready. A reply that does not match an entry waiting for one raises `rx_err` for that cycle and is dropped.

Top module: `mshr_unit`

## Requirements
- R1: After reset every entry is idle: `req_ready` is 1, and both `net_tx_valid` and `rsp_valid` are 0.
- R2: An accepted request goes into the lowest-numbered idle entry. The message for it shows that entry index on `net_tx_entry`, together with the request's write flag, cacheable flag, address and write data.
- R3: `req_ready` is 0 while all four entries are occupied. A request offered during that time is not taken and never produces a network message.
- R4: Network messages leave in the order their requests were accepted, oldest first, whatever their entry indices. While `net_tx_ready` is 0, `net_tx_valid` and the message fields hold steady.
- R5: A reply on `net_rx_entry` for an entry in the requested state makes that entry complete. The reply stream then returns the request's tag and write flag together with `net_rx_data`.
- R6: A reply for an entry that is not in the requested state (idle, pending or already complete) drives `rx_err` to 1 in that same cycle. The reply changes nothing: no reply-stream output appears, and any stored data is kept.
- R7: When several entries are complete, they go out on the reply stream one per transfer in round-robin order. The search starts at the index just after the last entry sent.
- R8: While `rsp_ready` is 0, the reply stream keeps presenting the same entry with an unchanged tag and data, even if more entries become complete.
- R9: The entry sent on the reply stream becomes idle after the transfer, and in the next cycle `req_ready` is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | An entry is free to take a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_cacheable | input | 1 | 1 = cacheable access |
| req_addr | input | 16 | Request address |
| req_tag | input | 5 | Reply destination tag |
| req_wdata | input | 32 | Store data |
| net_tx_valid | output | 1 | Request message available |
| net_tx_ready | input | 1 | Network takes the message |
| net_tx_entry | output | 2 | Entry index carried in the message |
| net_tx_write | output | 1 | Write flag of the message |
| net_tx_cacheable | output | 1 | Cacheable flag of the message |
| net_tx_addr | output | 16 | Address of the message |
| net_tx_wdata | output | 32 | Store data of the message |
| net_rx_valid | input | 1 | Reply arriving from the network |
| net_rx_ready | output | 1 | Always 1 |
| net_rx_entry | input | 2 | Entry index the reply belongs to |
| net_rx_data | input | 32 | Reply data |
| rx_err | output | 1 | Reply did not match a waiting entry |
| rsp_valid | output | 1 | Completed entry on the reply stream |
| rsp_ready | input | 1 | Reply register takes the entry |
| rsp_tag | output | 5 | Tag of the completed request |
| rsp_write | output | 1 | Write flag of the completed request |
| rsp_data | output | 32 | Reply data |

## Verification
The bench runs all 24 orders in which four outstanding replies can return, with the reply stream stalled. A design without a locked grant would switch its output to a lower-indexed entry when that entry finished later. A design without rotation would always start the drain at entry 0. A separate sequence frees entry 0 while entries 2 and 3 are still waiting to be sent. The recycled entry must then go out last; an index-priority sender would send it first. Stray replies are sent to idle, pending and completed entries. A design that accepted them would complete an entry early, or overwrite data that had already been stored.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_PENDING   = 2'd1,
    ST_REQUESTED = 2'd2,
    ST_COMPLETE  = 2'd3
  } mshr_state_e;
endpackage

// File: rtl/mshr_entry.sv
module mshr_entry
  import mshr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic              alloc_write,
  input  logic              alloc_cache,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic [DATA_W-1:0] alloc_wdata,
  input  logic              sent,
  input  logic              reply,
  input  logic [DATA_W-1:0] reply_data,
  input  logic              retire,
  output mshr_state_e       state,
  output logic              is_write,
  output logic              is_cache,
  output logic [ADDR_W-1:0] addr,
  output logic [TAG_W-1:0]  tag,
  output logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  mshr_state_e state_q;
  assign state = state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:      if (alloc)  state_q <= ST_PENDING;
        ST_PENDING:   if (sent)   state_q <= ST_REQUESTED;
        ST_REQUESTED: if (reply)  state_q <= ST_COMPLETE;
        ST_COMPLETE:  if (retire) state_q <= ST_IDLE;
        default:                  state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_write <= 1'b0;
      is_cache <= 1'b0;
      addr     <= '0;
      tag      <= '0;
      wdata    <= '0;
      rdata    <= '0;
    end else begin
      if (alloc && state_q == ST_IDLE) begin
        is_write <= alloc_write;
        is_cache <= alloc_cache;
        addr     <= alloc_addr;
        tag      <= alloc_tag;
        wdata    <= alloc_wdata;
      end
      if (reply && state_q == ST_REQUESTED) rdata <= reply_data;
    end
  end

  // R2: allocation only ever targets a free entry
  assert_alloc_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> state_q == ST_IDLE);
  // R5: completion is reached only from the requested state
  assert_complete_from_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COMPLETE && $past(state_q) != ST_COMPLETE) |-> $past(state_q) == ST_REQUESTED);
  // R6: stored reply data changes only while the entry awaits a reply
  assert_rdata_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COMPLETE && $past(state_q) == ST_COMPLETE) |-> $stable(rdata));
endmodule

// File: rtl/mshr_order_fifo.sv
module mshr_order_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         empty,
  output logic [W-1:0] head
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slot [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign head  = slot[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot[wr_ptr] <= push_data;
  end

  // R3: never more pending entries than entries exist
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < CW'(DEPTH) || pop));
  // R4: a message is only taken when one is queued
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/mshr_rr_arb.sv
module mshr_rr_arb #(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  input  logic                 out_ready,
  output logic                 any,
  output logic [$clog2(N)-1:0] grant
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] ptr_q, held_q, pick;
  logic          hold_q, found;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int o = 0; o < N; o++) begin
      if (!found && req[(int'(ptr_q) + o) % N]) begin
        found = 1'b1;
        pick  = IW'((int'(ptr_q) + o) % N);
      end
    end
  end

  assign any   = |req;
  assign grant = hold_q ? held_q : pick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      held_q <= '0;
      hold_q <= 1'b0;
    end else begin
      hold_q <= any && !out_ready;
      held_q <= grant;
      if (any && out_ready) ptr_q <= IW'((int'(grant) + 1) % N);
    end
  end

  // R7: the grant always names a requesting entry
  assert_grant_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> req[grant]);
  // R8: a stalled grant is kept in the next cycle
  assert_grant_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (any && !out_ready) |=> grant == $past(grant));
endmodule

// File: rtl/mshr_unit.sv
module mshr_unit
  import mshr_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int TAG_W       = 5,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_cacheable,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              net_tx_valid,
  input  logic              net_tx_ready,
  output logic [IDX_W-1:0]  net_tx_entry,
  output logic              net_tx_write,
  output logic              net_tx_cacheable,
  output logic [ADDR_W-1:0] net_tx_addr,
  output logic [DATA_W-1:0] net_tx_wdata,
  input  logic              net_rx_valid,
  output logic              net_rx_ready,
  input  logic [IDX_W-1:0]  net_rx_entry,
  input  logic [DATA_W-1:0] net_rx_data,
  output logic              rx_err,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic              rsp_write,
  output logic [DATA_W-1:0] rsp_data
);
  mshr_state_e       e_state [NUM_ENTRIES];
  logic              e_write [NUM_ENTRIES];
  logic              e_cache [NUM_ENTRIES];
  logic [ADDR_W-1:0] e_addr  [NUM_ENTRIES];
  logic [TAG_W-1:0]  e_tag   [NUM_ENTRIES];
  logic [DATA_W-1:0] e_wdata [NUM_ENTRIES];
  logic [DATA_W-1:0] e_rdata [NUM_ENTRIES];

  logic [NUM_ENTRIES-1:0] idle_vec, done_vec;
  logic [IDX_W-1:0]       alloc_idx, head_idx, rsp_idx;
  logic                   fifo_empty, req_fire, tx_fire, rsp_fire, rx_hit;

  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      idle_vec[i] = (e_state[i] == ST_IDLE);
      done_vec[i] = (e_state[i] == ST_COMPLETE);
    end
  end

  // lowest free entry wins allocation
  always_comb begin
    alloc_idx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (idle_vec[i]) alloc_idx = IDX_W'(i);
    end
  end

  assign req_ready = |idle_vec;
  assign req_fire  = req_valid && req_ready;
  assign tx_fire   = net_tx_valid && net_tx_ready;
  assign rsp_fire  = rsp_valid && rsp_ready;

  assign net_rx_ready = 1'b1;
  assign rx_hit       = net_rx_valid && (e_state[net_rx_entry] == ST_REQUESTED);
  assign rx_err       = net_rx_valid && !rx_hit;

  mshr_order_fifo #(.DEPTH(NUM_ENTRIES), .W(IDX_W)) i_order (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (req_fire),
    .push_data (alloc_idx),
    .pop       (tx_fire),
    .empty     (fifo_empty),
    .head      (head_idx)
  );

  mshr_rr_arb #(.N(NUM_ENTRIES)) i_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (done_vec),
    .out_ready (rsp_ready),
    .any       (rsp_valid),
    .grant     (rsp_idx)
  );

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
    mshr_entry #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) i_entry (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc       (req_fire && alloc_idx == IDX_W'(g)),
      .alloc_write (req_write),
      .alloc_cache (req_cacheable),
      .alloc_addr  (req_addr),
      .alloc_tag   (req_tag),
      .alloc_wdata (req_wdata),
      .sent        (tx_fire && head_idx == IDX_W'(g)),
      .reply       (rx_hit && net_rx_entry == IDX_W'(g)),
      .reply_data  (net_rx_data),
      .retire      (rsp_fire && rsp_idx == IDX_W'(g)),
      .state       (e_state[g]),
      .is_write    (e_write[g]),
      .is_cache    (e_cache[g]),
      .addr        (e_addr[g]),
      .tag         (e_tag[g]),
      .wdata       (e_wdata[g]),
      .rdata       (e_rdata[g])
    );
  end

  assign net_tx_valid     = !fifo_empty;
  assign net_tx_entry     = head_idx;
  assign net_tx_write     = e_write[head_idx];
  assign net_tx_cacheable = e_cache[head_idx];
  assign net_tx_addr      = e_addr[head_idx];
  assign net_tx_wdata     = e_wdata[head_idx];

  assign rsp_tag   = e_tag[rsp_idx];
  assign rsp_write = e_write[rsp_idx];
  assign rsp_data  = e_rdata[rsp_idx];

  // R4: a stalled message stays put
  assert_tx_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (net_tx_valid && !net_tx_ready) |=> (net_tx_valid && $stable(net_tx_entry) && $stable(net_tx_addr)));
  // R4: the entry being sent is one that is pending
  assert_tx_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    net_tx_valid |-> e_state[net_tx_entry] == ST_PENDING);
  // R8: a stalled reply stays put
  assert_rsp_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_tag) && $stable(rsp_data)));
  // R9: a retired entry frees space
  assert_ready_after_retire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire |=> req_ready);
  // R6: flagged replies leave no mark on the reply stream
  assert_err_no_effect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err && !rsp_valid) |=> !rsp_valid);
endmodule

// File: tb/test_mshr_unit.sv
module test_mshr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_write = 0, req_cacheable = 0;
  logic [15:0] req_addr = 0;
  logic [4:0]  req_tag = 0;
  logic [31:0] req_wdata = 0;
  logic        req_ready;
  logic        net_tx_valid, net_tx_write, net_tx_cacheable;
  logic        net_tx_ready = 0;
  logic [1:0]  net_tx_entry;
  logic [15:0] net_tx_addr;
  logic [31:0] net_tx_wdata;
  logic        net_rx_valid = 0, net_rx_ready;
  logic [1:0]  net_rx_entry = 0;
  logic [31:0] net_rx_data = 0;
  logic        rx_err, rsp_valid, rsp_write;
  logic        rsp_ready = 0;
  logic [4:0]  rsp_tag;
  logic [31:0] rsp_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mshr_unit i_mshr_unit (.*);

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [4:0] tag_of(int r, int i);
    return 5'((r * 4 + i) % 32);
  endfunction
  function automatic logic [15:0] addr_of(int r, int i);
    return 16'(16'h1000 + r * 16 + i);
  endfunction
  function automatic logic [31:0] wd_of(int r, int i);
    return 32'(32'hD000_0000 + r * 256 + i);
  endfunction
  function automatic logic [31:0] rd_of(int r, int i);
    return 32'hA000_0000 ^ 32'(r << 8) ^ 32'(i);
  endfunction

  // offer one request; expect it to be taken
  task automatic put_req(input int r, input int i);
    req_valid = 1; req_write = i[0]; req_cacheable = i[1] ^ r[0];
    req_addr = addr_of(r, i); req_tag = tag_of(r, i); req_wdata = wd_of(r, i);
    #1 chk(req_ready === 1'b1, "R2 ready", 64'(req_ready), 1);
    step();
    req_valid = 0;
  endtask

  // expect message for entry e carrying request (r,i) and take it
  task automatic take_tx(input int e, input int r, input int i);
    net_tx_ready = 1;
    #1;
    chk(net_tx_valid === 1'b1 && net_tx_entry === 2'(e), "R4 order", 64'(net_tx_entry), 64'(e));
    chk(net_tx_addr === addr_of(r, i) && net_tx_wdata === wd_of(r, i) &&
        net_tx_write === i[0] && net_tx_cacheable === (i[1] ^ r[0]),
        "R2 fields", 64'(net_tx_addr), 64'(addr_of(r, i)));
    step();
    net_tx_ready = 0;
  endtask

  task automatic send_rx(input int e, input logic [31:0] d, input bit expect_err);
    net_rx_valid = 1; net_rx_entry = 2'(e); net_rx_data = d;
    #1 chk(rx_err === expect_err, expect_err ? "R6 err" : "R5 no err", 64'(rx_err), 64'(expect_err));
    step();
    net_rx_valid = 0;
  endtask

  task automatic take_rsp(input int r, input int i, input logic [31:0] d);
    rsp_ready = 1;
    #1;
    chk(rsp_valid === 1'b1 && rsp_tag === tag_of(r, i), "R7 rr order", 64'(rsp_tag), 64'(tag_of(r, i)));
    chk(rsp_data === d && rsp_write === i[0], "R5 data", 64'(rsp_data), 64'(d));
    step();
    rsp_ready = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int perm[4];
    step(); step();
    rst_n = 1;
    #1;
    chk(req_ready === 1'b1, "R1 ready", 64'(req_ready), 1);
    chk(net_tx_valid === 1'b0, "R1 tx", 64'(net_tx_valid), 0);
    chk(rsp_valid === 1'b0, "R1 rsp", 64'(rsp_valid), 0);
    @(negedge clk);

    // sweep all 24 reply orders
    for (int q = 0; q < 24; q++) begin
      int avail[4];
      int rem;
      rem = q;
      for (int k = 0; k < 4; k++) avail[k] = k;
      for (int k = 0; k < 4; k++) begin
        int f, sel;
        f = (k == 0) ? 6 : (k == 1) ? 2 : 1;
        if (k == 3) f = 1;
        sel = rem / f;
        rem = rem % f;
        perm[k] = avail[sel];
        for (int m = sel; m < 3; m++) avail[m] = avail[m + 1];
      end
      for (int i = 0; i < 4; i++) put_req(q, i);
      // R3: full, a fifth request is refused
      req_valid = 1; req_addr = 16'hFFFF; req_tag = 5'h1F;
      #1 chk(req_ready === 1'b0, "R3 full", 64'(req_ready), 0);
      step(); step();
      req_valid = 0;
      // R4: stalled message holds
      #1 chk(net_tx_valid === 1'b1 && net_tx_entry === 2'd0, "R4 hold", 64'(net_tx_entry), 0);
      @(negedge clk);
      for (int i = 0; i < 4; i++) take_tx(i, q, i);
      #1 chk(net_tx_valid === 1'b0, "R3 no extra msg", 64'(net_tx_valid), 0);
      @(negedge clk);
      for (int k = 0; k < 4; k++) send_rx(perm[k], rd_of(q, perm[k]), 0);
      // R8: the first completed entry is held under stall
      #1 chk(rsp_valid === 1'b1 && rsp_tag === tag_of(q, perm[0]), "R8 hold", 64'(rsp_tag), 64'(tag_of(q, perm[0])));
      step();
      #1 chk(rsp_tag === tag_of(q, perm[0]) && rsp_data === rd_of(q, perm[0]), "R8 stable", 64'(rsp_tag), 64'(tag_of(q, perm[0])));
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
        int e;
        e = (perm[0] + k) % 4;
        take_rsp(q, e, rd_of(q, e));
      end
      #1;
      chk(rsp_valid === 1'b0, "R9 drained", 64'(rsp_valid), 0);
      chk(req_ready === 1'b1, "R9 free", 64'(req_ready), 1);
      @(negedge clk);
    end

    // oldest-first with a recycled low entry, plus stray replies
    send_rx(2, 32'h5, 1);                       // R6 idle entry
    #1 chk(rsp_valid === 1'b0, "R6 idle no rsp", 64'(rsp_valid), 0);
    @(negedge clk);
    for (int i = 0; i < 4; i++) put_req(30, i);
    send_rx(2, 32'h6, 1);                       // R6 pending entry
    take_tx(0, 30, 0);
    take_tx(1, 30, 1);
    send_rx(0, rd_of(30, 0), 0);
    take_rsp(30, 0, rd_of(30, 0));
    put_req(31, 0);                             // reuses entry 0, youngest
    take_tx(2, 30, 2);
    take_tx(3, 30, 3);
    take_tx(0, 31, 0);
    send_rx(1, rd_of(30, 1), 0);
    send_rx(1, 32'hBAD, 1);                     // R6 already complete
    take_rsp(30, 1, rd_of(30, 1));
    send_rx(2, rd_of(30, 2), 0);
    send_rx(3, rd_of(30, 3), 0);
    send_rx(0, rd_of(31, 0), 0);
    take_rsp(30, 2, rd_of(30, 2));
    take_rsp(30, 3, rd_of(30, 3));
    take_rsp(31, 0, rd_of(31, 0));
    #1 chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R9 end", 64'(rsp_valid), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule